// File: doc/BRIEF.md
# Pipelined Valid-Qualified Dual-Clock FIFO

This block is a first-in-first-out buffer for wide words at high clock rates, with the write side and the read side each running on its own clock. The two clocks may be the same clock or unrelated. Pointers cross between the domains as Gray codes through two-flop synchronisers. The full and empty flags come from the synchronised copies, so a flag may lag the true state but never reports room or data that is not there.

To keep every path short, the read side is a pipeline. The request, the memory address, the memory output and the output word each sit in their own register. A read request returns its word exactly three read-clock edges after the edge that sampled it. The word is marked by a one-cycle valid strobe. There is no show-ahead: nothing reaches the output unless it was asked for. Readers are expected to take every word the block returns, because no back-pressure is applied to returned data. A downstream consumer that needs zero read latency places its own small buffer after this block.

After reset each side holds its ready output low through a flush interval. The interval lasts until both sides have counted at least `FLUSH_CYC` cycles of their own clock, so it covers at least that many cycles of the slower clock. Requests made while not ready are ignored.

Top module: `vq_dcfifo`

## Requirements
- R1: Capacity is `DEPTH` words. `DATA_W` and `DEPTH` must be whole multiples of a block unit of `BLK_W` bits by `BLK_D` entries (default 32 by 512). With the reader idle, exactly `DEPTH` writes are accepted before `wfull` rises.
- R2: A read request sampled at read-clock edge k and accepted returns its word on `rdata` with `rvalid` high after edge k+3. The returned word holds for one cycle.
- R3: `rvalid` is high only for words that were requested. There is no show-ahead: written data never reaches the output while `rreq` stays low. `rdata` carries meaning only while `rvalid` is high, and it is not reset.
- R4: After reset, `wready` and `rready` stay low for at least `FLUSH_CYC` cycles of the slower clock. Each then rises and stays high until the next reset.
- R5: Write and read requests made while the side is not ready are ignored: no word is stored and no `rvalid` is produced.
- R6: A continuous read burst over stored data returns one valid word per read cycle, with no gaps, until the FIFO is empty.
- R7: Words are returned in the order they were written, with unrelated write and read clocks and under irregular request patterns.
- R8: A write request while `wfull` is high is dropped and leaves the stored contents unchanged.
- R9: A read request while `rempty` is high is dropped and produces no `rvalid`.
- R10: Once flushed with nothing written, `rempty` is high and `wfull` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| wreq | input | 1 | Write request |
| wdata | input | DATA_W | Word to store |
| wfull | output | 1 | No room; writes are dropped |
| wready | output | 1 | Write side has finished its flush interval |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| rreq | input | 1 | Read request |
| rdata | output | DATA_W | Returned word, meaningful only with rvalid |
| rvalid | output | 1 | Marks the cycle a requested word is on rdata |
| rempty | output | 1 | No stored word visible to the reader |
| rready | output | 1 | Read side has finished its flush interval |

## Verification
The hardest state to reach from the ports is a full FIFO whose writer keeps pushing. The bench must also show that the extra words really vanish, which only becomes visible once everything has been drained. To get there, the bench writes several words more than the capacity while the reader is idle. It then reads back with a burst longer than the contents. That single burst proves three things at once: the count and order of the surviving words, the absence of gaps, and that the trailing reads on an empty FIFO return nothing. The flush interval is exercised by requesting on both sides from the moment reset is released, and then confirming the FIFO is still empty.

// File: rtl/vq_dcfifo.sv
module vq_dcfifo #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 512,
  parameter int BLK_W     = 32,
  parameter int BLK_D     = 512,
  parameter int FLUSH_CYC = 32
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wreq,
  input  logic [DATA_W-1:0] wdata,
  output logic              wfull,
  output logic              wready,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rreq,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              rempty,
  output logic              rready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(FLUSH_CYC + 1);

  // R1 geometry rule, checked at elaboration
  if ((DATA_W % BLK_W) != 0 || (DEPTH % BLK_D) != 0 || AW < 2) begin : g_bad_geometry
    $error("vq_dcfifo: width and depth must be whole block units");
  end

  logic [DATA_W-1:0] mem [DEPTH];

  // write domain
  logic [AW:0]   wbin, wgray, rg_s1, rg_s2;
  logic [CW-1:0] wcnt;
  logic          wdone, rdone_s1, rdone_s2;
  logic          wacc;
  logic [AW:0]   wbin_nxt;

  assign wready   = wdone & rdone_s2;
  assign wfull    = (wgray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
  assign wacc     = wreq & ~wfull & wready;
  assign wbin_nxt = wbin + (AW+1)'(wacc);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      wcnt <= '0; wdone <= 1'b0; rdone_s1 <= 1'b0; rdone_s2 <= 1'b0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      rg_s1 <= rgray; rg_s2 <= rg_s1;
      rdone_s1 <= rdone; rdone_s2 <= rdone_s1;
      if (!wdone) wcnt <= wcnt + 1'b1;
      if (wcnt == CW'(FLUSH_CYC - 1)) wdone <= 1'b1;
    end
  end

  always_ff @(posedge wclk)
    if (wacc) mem[wbin[AW-1:0]] <= wdata;

  // read domain
  logic [AW:0]   rbin, rgray, wg_s1, wg_s2;
  logic [CW-1:0] rcnt;
  logic          rdone, wdone_s1, wdone_s2;
  logic          rreq_q, racc, v1, v2;
  logic [AW-1:0] raddr_q;
  logic [DATA_W-1:0] mem_q;
  logic [AW:0]   rbin_nxt;

  assign rready   = rdone & wdone_s2;
  assign rempty   = (rgray == wg_s2);
  assign racc     = rreq_q & ~rempty & rready;
  assign rbin_nxt = rbin + (AW+1)'(racc);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      rcnt <= '0; rdone <= 1'b0; wdone_s1 <= 1'b0; wdone_s2 <= 1'b0;
      rreq_q <= 1'b0; raddr_q <= '0; v1 <= 1'b0; v2 <= 1'b0; rvalid <= 1'b0;
    end else begin
      rreq_q  <= rreq;
      if (racc) raddr_q <= rbin[AW-1:0];
      rbin    <= rbin_nxt;
      rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
      v1      <= racc;
      v2      <= v1;
      rvalid  <= v2;
      wg_s1 <= wgray; wg_s2 <= wg_s1;
      wdone_s1 <= wdone; wdone_s2 <= wdone_s1;
      if (!rdone) rcnt <= rcnt + 1'b1;
      if (rcnt == CW'(FLUSH_CYC - 1)) rdone <= 1'b1;
    end
  end

  always_ff @(posedge rclk) begin
    mem_q <= mem[raddr_q];
    rdata <= mem_q;
  end

  // assertions
  assert_valid_latency_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
    rvalid |-> ($past(rreq, 4) && $past(rready, 3)));

  assert_no_showahead_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!$past(rreq, 4)) |-> !rvalid);

  assert_wready_sticky_R4: assert property (@(posedge wclk) disable iff (!wrst_n)
    wready |=> wready);

  assert_rready_sticky_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    rready |=> rready);

  assert_no_overflow_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wreq && wfull) |=> (wbin == $past(wbin)));

  assert_no_underflow_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rreq_q && rempty) |=> (rbin == $past(rbin)));

  assert_flush_blocks_write_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    !wready |=> (wbin == $past(wbin)));
endmodule

// File: tb/sim_vq_dcfifo.sv
module sim_vq_dcfifo;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DW = 32;
  localparam int DEPTH = 512;
  localparam int FLUSH = 32;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wreq = 0, rreq = 0;
  logic [DW-1:0] wdata = '0;
  logic wfull, wready, rvalid, rempty, rready;
  logic [DW-1:0] rdata;

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  vq_dcfifo #(.DATA_W(DW), .DEPTH(DEPTH), .FLUSH_CYC(FLUSH)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wreq(wreq), .wdata(wdata), .wfull(wfull), .wready(wready),
    .rclk(rclk), .rrst_n(rrst_n), .rreq(rreq), .rdata(rdata), .rvalid(rvalid),
    .rempty(rempty), .rready(rready));

  int tests = 0, fails = 0, vcount = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];

  task automatic check(bit ok, string req, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops expected words as valid words come out
  always @(posedge rclk) begin
    #1;
    if (rrst_n && rvalid) begin
      vcount++;
      if (exp_q.size() == 0) check(0, "R3 unrequested valid", rdata, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rdata == e, "R7 order", rdata, e);
      end
    end
  end

  task automatic put(input logic [DW-1:0] d);
    @(negedge wclk);
    wreq = 1; wdata = d;
    if (!wfull && wready) exp_q.push_back(d);
  endtask

  task automatic wend;
    @(negedge wclk); wreq = 0;
  endtask

  task automatic burst(input int n, output int got, output bit gap);
    int first = -1, last = -1;
    got = 0;
    for (int i = 0; i < n + 10; i++) begin
      @(negedge rclk); rreq = (i < n);
      @(posedge rclk); #1;
      if (rvalid) begin
        if (first < 0) first = i;
        last = i; got++;
      end
    end
    gap = (got > 0) && (last - first + 1 != got);
  endtask

  initial begin
    repeat (5000) @(posedge wclk);
    while (!done) begin
      repeat (145000) @(posedge wclk);
      if (!done) begin
        check(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    time t0, tw, tr;
    int got, n;
    bit gap;
    repeat (3) @(posedge rclk);
    check(rvalid == 0, "R4 reset rvalid", rvalid, 0);
    check(wready == 0 && rready == 0, "R4 reset ready", {wready, rready}, 0);
    #3; wrst_n = 1; rrst_n = 1; t0 = $time;

    // R5: requests during flush
    fork
      begin
        n = 0;
        while (1) begin
          @(negedge wclk);
          if (wready) break;
          wreq = 1; wdata = 32'hBAD0_0000 + n; n++;
        end
        wreq = 0; tw = $time;
      end
      begin
        while (1) begin
          @(negedge rclk);
          if (rready) break;
          rreq = 1;
        end
        rreq = 0; tr = $time;
      end
    join
    check(tw - t0 >= FLUSH * RCLK_PERIOD, "R4 wready flush length", tw - t0, FLUSH * RCLK_PERIOD);
    check(tr - t0 >= FLUSH * RCLK_PERIOD, "R4 rready flush length", tr - t0, FLUSH * RCLK_PERIOD);
    repeat (20) @(negedge rclk);
    check(rempty == 1, "R5 flush writes ignored / R10 empty", rempty, 1);
    check(wfull == 0, "R10 not full", wfull, 0);
    check(vcount == 0, "R5 no valid from flush reads", vcount, 0);
    check(wready && rready, "R4 ready held", {wready, rready}, 3);

    // R3: no show-ahead
    for (int i = 0; i < 5; i++) put(32'h1000 + i);
    wend();
    repeat (30) @(negedge rclk);
    check(vcount == 0, "R3 no show-ahead", vcount, 0);
    check(rempty == 0, "R10 not empty after writes", rempty, 0);

    // R2: single read latency
    @(negedge rclk); rreq = 1;
    @(negedge rclk); rreq = 0;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge rclk); #1; n++;
      if (rvalid) break;
    end
    check(n == 3, "R2 read latency", n, 3);
    @(posedge rclk); #1;
    check(rvalid == 0, "R2 single-cycle strobe", rvalid, 0);
    burst(4, got, gap);
    check(got == 4 && !gap, "R6 short burst", got, 4);

    // R9: read while empty
    repeat (10) @(negedge rclk);
    n = vcount;
    @(negedge rclk); rreq = 1;
    @(negedge rclk); rreq = 0;
    repeat (8) @(negedge rclk);
    check(vcount == n, "R9 empty read dropped", vcount - n, 0);
    check(rempty == 1, "R9 still empty", rempty, 1);

    // R1/R8: overfill, then drain with one long burst
    n = 0;
    for (int i = 0; i < DEPTH + 4; i++) begin
      @(negedge wclk);
      wreq = 1; wdata = 32'h0002_0000 + i;
      if (!wfull && wready) begin exp_q.push_back(wdata); n++; end
    end
    wend();
    check(n == DEPTH, "R1 capacity", n, DEPTH);
    check(wfull == 1, "R8 full flag", wfull, 1);
    repeat (10) @(negedge rclk);
    burst(DEPTH + 6, got, gap);
    check(got == DEPTH, "R8 extra writes dropped", got, DEPTH);
    check(!gap, "R6 burst without gaps", gap, 0);
    check(exp_q.size() == 0, "R9 trailing reads dropped", exp_q.size(), 0);

    // R7: irregular traffic on unrelated clocks
    fork
      begin
        int w = 0, k = 0;
        while (w < 150) begin
          @(negedge wclk); k++;
          if (k % 3 == 2) wreq = 0;
          else begin
            wreq = 1; wdata = 32'h00AB_0000 + w * 7;
            if (!wfull && wready) begin exp_q.push_back(wdata); w++; end
          end
        end
        wend();
      end
      begin
        for (int k = 0; k < 600; k++) begin
          @(negedge rclk); rreq = (k % 5 != 1);
        end
        rreq = 0;
      end
    join
    repeat (20) @(negedge rclk);
    check(exp_q.size() == 0, "R7 all words returned", exp_q.size(), 0);
    check(rempty == 1, "R10 empty after drain", rempty, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule